// File: doc/BRIEF.md
# Loop-aware micro-sequencer

This block steps through a small on-chip program of 36-bit control words and presents the user-control field of the word at the current program counter. Counted loops are closed in hardware. A loop-setup instruction loads an iteration count, a loop-start address and a loop-end address into a set of loop registers. Whenever the program counter reaches the loop-end address, comparison logic either sends it back to the start or lets it fall through. The loop body therefore contains no decrement or branch instruction and costs no extra cycle per pass.

The same instruction set also provides a conditional jump on one of four external condition inputs, a subroutine call and return, and a halt. Loop registers and return addresses share one internal frame stack. This lets loops nest inside loops and inside subroutines. When a nested loop ends or a subroutine returns, the enclosing context comes back exactly as it was. Stack overflow and underflow are recorded in two sticky flags. The program ROM holds a fixed test program. The datapath driven by the control field is outside the block.

Instruction fields (bit positions): opcode [35:33], count [32:25], start address [24:18], end/destination address [17:11], user control [10:0]. Opcodes: 0 plain, 1 loop setup, 2 conditional jump, 3 call, 4 return, 5 halt. In the built-in program the user field of every word at address `a` is `{4'hA, a}`.

Top module: `loopseq`

## Requirements
- R1: A synchronous reset (`rst` high) sets the program counter to 0x04, clears the loop count, empties the stack and clears both error flags.
- R2: For a word that changes no control flow, the counter advances by one per cycle, and `ctrl_o` always equals bits [10:0] of the word at the current counter in the same cycle.
- R3: A loop-setup word (opcode 1) pushes the current loop registers and then loads count [32:25], start [24:18] and end [17:11]; a count of 0 is loaded as 1, so the body runs once.
- R4: When the counter equals the loop-end address and the loop count is greater than 1, the next counter is the loop-start address and the count drops by one.
- R5: When the counter equals the loop-end address and the loop count is exactly 1 (last pass), the counter advances by one and the loop registers are popped from the stack, restoring the enclosing loop.
- R6: At a loop-end address with a live count, loop closing takes priority: the word's own jump, call, return or setup action is suppressed on that cycle.
- R7: A conditional jump (opcode 2) goes to the destination field when `cond_i[count[1:0]]` is 1, else to the next address; `cond_i` has no effect on any other opcode.
- R8: A call (opcode 3) pushes the return address (counter+1) together with the loop registers, clears the loop count and jumps to the destination; a return (opcode 4) pops that frame, restoring the loop registers and jumping to the saved address.
- R9: A halt word (opcode 5) holds the counter at its own address.
- R10: The stack holds 128 frames; a push when all 128 are in use sets the sticky `ovf_o`, leaves the stack unchanged and makes the call or setup word fall through to the next address with loop registers unchanged.
- R11: A pop with an empty stack sets the sticky `unf_o` and leaves the stack empty; a return then falls through to the next address, and a last pass clears the loop count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cond_i | input | 4 | External condition inputs tested by conditional jumps |
| ctrl_o | output | 11 | User-control field of the current word |
| pc_o | output | 7 | Current program counter |
| ovf_o | output | 1 | Sticky stack-overflow flag |
| unf_o | output | 1 | Sticky stack-underflow flag |

## Verification
The bench follows a cycle-exact counter trace through several cases. An inner loop whose body is a single word is nested in an outer loop, so a design that restored the wrong frame on the inner last pass would repeat or skip the outer body. Other cases are a zero-count loop, a subroutine called from inside a loop that runs its own loop, and a jump word at a loop-end address with its condition true, which would wrongly leave the loop if closing lacked priority. A self-calling word then fills the stack. The 129th push must fail exactly on its cycle and fall through, and the following returns must unwind 128 frames before one underflow. An off-by-one full test or a pointer that moved on a failed push would shift both of these events by a cycle or send the counter to a stale address. Condition inputs are held high on words that are not jumps to show they are ignored there.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  localparam int ADDR_W = 7;
  localparam int OP_W   = 3;
  localparam int CNT_W  = 8;
  localparam int USR_W  = 11;
  localparam int NCOND  = 4;
  localparam int SEL_W  = $clog2(NCOND);
  localparam int WORD_W = OP_W + CNT_W + 2 * ADDR_W + USR_W;
  localparam int TAG_W  = USR_W - ADDR_W;

  localparam logic [OP_W-1:0] OP_NOP  = 3'd0;
  localparam logic [OP_W-1:0] OP_LOOP = 3'd1;
  localparam logic [OP_W-1:0] OP_JIF  = 3'd2;
  localparam logic [OP_W-1:0] OP_CALL = 3'd3;
  localparam logic [OP_W-1:0] OP_RET  = 3'd4;
  localparam logic [OP_W-1:0] OP_HALT = 3'd5;

  localparam logic [TAG_W-1:0] USR_TAG = 4'hA;

  // one stack frame: return address plus the full loop context
  typedef struct packed {
    logic [ADDR_W-1:0] ret;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] start;
    logic [ADDR_W-1:0] fin;
  } frame_t;

  function automatic logic [WORD_W-1:0] mk_word(
    input logic [OP_W-1:0] op, input logic [CNT_W-1:0] c,
    input logic [ADDR_W-1:0] s, input logic [ADDR_W-1:0] d,
    input logic [USR_W-1:0] u);
    return {op, c, s, d, u};
  endfunction

  function automatic logic [OP_W-1:0] f_op(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: OP_W];
  endfunction

  function automatic logic [CNT_W-1:0] f_cnt(input logic [WORD_W-1:0] w);
    return w[USR_W + 2*ADDR_W +: CNT_W];
  endfunction

  function automatic logic [ADDR_W-1:0] f_start(input logic [WORD_W-1:0] w);
    return w[USR_W + ADDR_W +: ADDR_W];
  endfunction

  function automatic logic [ADDR_W-1:0] f_dst(input logic [WORD_W-1:0] w);
    return w[USR_W +: ADDR_W];
  endfunction

  function automatic logic [USR_W-1:0] f_usr(input logic [WORD_W-1:0] w);
    return w[USR_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] pc_inc(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  // a zero count still runs the body once
  function automatic logic [CNT_W-1:0] load_count(input logic [CNT_W-1:0] c);
    return (c == '0) ? CNT_W'(1) : c;
  endfunction
endpackage

// File: rtl/lsq_rom.sv
module lsq_rom
  import lsq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] word
);
  function automatic logic [WORD_W-1:0] prog_word(input logic [ADDR_W-1:0] a);
    logic [USR_W-1:0] u;
    u = {USR_TAG, a};
    case (a)
      7'd4:  return mk_word(OP_LOOP, 8'd2, 7'd5,  7'd8,  u);  // outer loop
      7'd6:  return mk_word(OP_LOOP, 8'd3, 7'd7,  7'd7,  u);  // one-word inner loop
      7'd9:  return mk_word(OP_LOOP, 8'd0, 7'd10, 7'd10, u);  // zero count
      7'd11: return mk_word(OP_JIF,  8'd1, 7'd0,  7'd14, u);
      7'd12: return mk_word(OP_JIF,  8'd0, 7'd0,  7'd11, u);
      7'd13: return mk_word(OP_HALT, 8'd0, 7'd0,  7'd0,  u);
      7'd14: return mk_word(OP_LOOP, 8'd2, 7'd15, 7'd16, u);
      7'd15: return mk_word(OP_CALL, 8'd0, 7'd0,  7'd20, u);
      7'd17: return mk_word(OP_LOOP, 8'd2, 7'd18, 7'd18, u);
      7'd18: return mk_word(OP_JIF,  8'd2, 7'd0,  7'd30, u);  // jump at loop end
      7'd19: return mk_word(OP_JIF,  8'd2, 7'd0,  7'd24, u);
      7'd20: return mk_word(OP_LOOP, 8'd2, 7'd21, 7'd21, u);  // loop in subroutine
      7'd22: return mk_word(OP_RET,  8'd0, 7'd0,  7'd0,  u);
      7'd24: return mk_word(OP_CALL, 8'd0, 7'd0,  7'd24, u);  // self call fills stack
      7'd25: return mk_word(OP_RET,  8'd0, 7'd0,  7'd0,  u);
      7'd26: return mk_word(OP_HALT, 8'd0, 7'd0,  7'd0,  u);
      default: return mk_word(OP_NOP, 8'd0, 7'd0, 7'd0, u);
    endcase
  endfunction

  always_comb word = prog_word(addr);
endmodule

// File: rtl/lsq_stack.sv
module lsq_stack
  import lsq_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   push,
  input  logic   pop,
  input  frame_t wr_fr,
  output frame_t top_fr,
  output logic   full,
  output logic   empty,
  output logic   ovf,
  output logic   unf
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int SP_W  = $clog2(DEPTH + 1);

  frame_t            mem [DEPTH];
  logic [SP_W-1:0]   sp;
  logic [IDX_W-1:0]  wr_idx, top_idx;
  logic              push_ok, pop_ok, push_bad, pop_bad;

  assign full     = (sp == SP_W'(DEPTH));
  assign empty    = (sp == '0);
  assign push_ok  = push && !full;
  assign pop_ok   = pop && !empty;
  assign push_bad = push && full;
  assign pop_bad  = pop && empty;
  assign wr_idx   = IDX_W'(sp);
  assign top_idx  = IDX_W'(sp - SP_W'(1));
  assign top_fr   = mem[top_idx];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_idx] <= wr_fr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp  <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      if (push_ok)      sp <= sp + SP_W'(1);
      else if (pop_ok)  sp <= sp - SP_W'(1);
      if (push_bad) ovf <= 1'b1;
      if (pop_bad)  unf <= 1'b1;
    end
  end

  a_r1_reset_empty: assert property (@(posedge clk)
    rst |=> (sp == '0) && !ovf && !unf);
  a_r8_single_op: assert property (@(posedge clk) disable iff (rst)
    !(push && pop));
  a_r10_full_hold: assert property (@(posedge clk) disable iff (rst)
    push_bad |=> (sp == $past(sp)) && ovf);
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  a_r11_empty_hold: assert property (@(posedge clk) disable iff (rst)
    pop_bad |=> (sp == '0) && unf);
  a_r11_unf_sticky: assert property (@(posedge clk) disable iff (rst)
    unf |=> unf);
endmodule

// File: rtl/lsq_flow.sv
module lsq_flow
  import lsq_pkg::*;
(
  input  logic [ADDR_W-1:0] pc,
  input  logic [OP_W-1:0]   op,
  input  logic [CNT_W-1:0]  cfield,
  input  logic [ADDR_W-1:0] sfield,
  input  logic [ADDR_W-1:0] dfield,
  input  logic [NCOND-1:0]  cond,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [ADDR_W-1:0] start,
  input  logic [ADDR_W-1:0] fin,
  input  frame_t            top_fr,
  input  logic              full,
  input  logic              empty,
  output logic [ADDR_W-1:0] pc_nx,
  output logic [CNT_W-1:0]  cnt_nx,
  output logic [ADDR_W-1:0] start_nx,
  output logic [ADDR_W-1:0] fin_nx,
  output logic              push,
  output logic              pop,
  output frame_t            wr_fr,
  output logic              loop_back,
  output logic              last_pass,
  output logic              call_ev,
  output logic              halt_ev
);
  logic             at_end;
  logic [SEL_W-1:0] sel;

  assign at_end    = (pc == fin) && (cnt != '0);
  assign loop_back = at_end && (cnt != CNT_W'(1));
  assign last_pass = at_end && (cnt == CNT_W'(1));
  assign sel       = cfield[SEL_W-1:0];
  assign call_ev   = !at_end && (op == OP_CALL);
  assign halt_ev   = !at_end && (op == OP_HALT);
  assign wr_fr     = '{ret: pc_inc(pc), cnt: cnt, start: start, fin: fin};

  always_comb begin
    pc_nx    = pc_inc(pc);
    cnt_nx   = cnt;
    start_nx = start;
    fin_nx   = fin;
    push     = 1'b0;
    pop      = 1'b0;
    if (loop_back) begin
      pc_nx  = start;
      cnt_nx = cnt - CNT_W'(1);
    end else if (last_pass) begin
      pop = 1'b1;
      if (!empty) begin
        cnt_nx   = top_fr.cnt;
        start_nx = top_fr.start;
        fin_nx   = top_fr.fin;
      end else begin
        cnt_nx = '0;
      end
    end else begin
      case (op)
        OP_LOOP: begin
          push = 1'b1;
          if (!full) begin
            cnt_nx   = load_count(cfield);
            start_nx = sfield;
            fin_nx   = dfield;
          end
        end
        OP_JIF: if (cond[sel]) pc_nx = dfield;
        OP_CALL: begin
          push = 1'b1;
          if (!full) begin
            pc_nx  = dfield;
            cnt_nx = '0;
          end
        end
        OP_RET: begin
          pop = 1'b1;
          if (!empty) begin
            pc_nx    = top_fr.ret;
            cnt_nx   = top_fr.cnt;
            start_nx = top_fr.start;
            fin_nx   = top_fr.fin;
          end
        end
        OP_HALT: pc_nx = pc;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/loopseq.sv
module loopseq
  import lsq_pkg::*;
#(
  parameter int                DEPTH    = 128,
  parameter logic [ADDR_W-1:0] RESET_PC = 7'h04
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCOND-1:0]  cond_i,
  output logic [USR_W-1:0]  ctrl_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              ovf_o,
  output logic              unf_o
);
  logic [ADDR_W-1:0] pc, start, fin, pc_nx, start_nx, fin_nx;
  logic [CNT_W-1:0]  cnt, cnt_nx;
  logic [WORD_W-1:0] word;
  logic              push, pop, full, empty;
  logic              loop_back, last_pass, call_ev, halt_ev;
  frame_t            wr_fr, top_fr;

  lsq_rom u_rom (.addr(pc), .word(word));

  lsq_flow u_flow (
    .pc(pc), .op(f_op(word)), .cfield(f_cnt(word)), .sfield(f_start(word)),
    .dfield(f_dst(word)), .cond(cond_i), .cnt(cnt), .start(start), .fin(fin),
    .top_fr(top_fr), .full(full), .empty(empty),
    .pc_nx(pc_nx), .cnt_nx(cnt_nx), .start_nx(start_nx), .fin_nx(fin_nx),
    .push(push), .pop(pop), .wr_fr(wr_fr),
    .loop_back(loop_back), .last_pass(last_pass),
    .call_ev(call_ev), .halt_ev(halt_ev)
  );

  lsq_stack #(.DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .wr_fr(wr_fr),
    .top_fr(top_fr), .full(full), .empty(empty), .ovf(ovf_o), .unf(unf_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= RESET_PC;
      cnt   <= '0;
      start <= '0;
      fin   <= '0;
    end else begin
      pc    <= pc_nx;
      cnt   <= cnt_nx;
      start <= start_nx;
      fin   <= fin_nx;
    end
  end

  assign pc_o   = pc;
  assign ctrl_o = f_usr(word);

  a_r1_reset_pc: assert property (@(posedge clk)
    rst |=> (pc == RESET_PC) && (cnt == '0));
  a_r4_loop_back: assert property (@(posedge clk) disable iff (rst)
    loop_back |=> (pc == $past(start)) && (cnt == $past(cnt) - CNT_W'(1)));
  a_r5_last_pass: assert property (@(posedge clk) disable iff (rst)
    last_pass |=> (pc == $past(pc) + ADDR_W'(1)));
  a_r8_call_jump: assert property (@(posedge clk) disable iff (rst)
    (call_ev && !full) |=> (pc == $past(f_dst(word))) && (cnt == '0));
  a_r9_halt: assert property (@(posedge clk) disable iff (rst)
    halt_ev |=> $stable(pc));
endmodule

// File: tb/loopseq_bench.sv
module loopseq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 36;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cond_i = 4'h0;
  logic [10:0] ctrl_o;
  logic [6:0]  pc_o;
  logic        ovf_o, unf_o;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  loopseq u_loopseq (.clk(clk), .rst(rst), .cond_i(cond_i), .ctrl_o(ctrl_o),
                     .pc_o(pc_o), .ovf_o(ovf_o), .unf_o(unf_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  // row = {cond driven in that cycle, expected pc}
  localparam logic [10:0] VEC [NROWS] = '{
    {4'hF, 7'd4},  {4'hF, 7'd5},  {4'hF, 7'd6},            // R3 outer setup, R7 cond ignored
    {4'hF, 7'd7},  {4'hF, 7'd7},  {4'hF, 7'd7},            // R4 single-word inner loop
    {4'hF, 7'd8},                                          // R5 inner last pass restores outer
    {4'hF, 7'd5},  {4'hF, 7'd6},                           // R4 outer loop back
    {4'hF, 7'd7},  {4'hF, 7'd7},  {4'hF, 7'd7},  {4'hF, 7'd8},
    {4'hF, 7'd9},  {4'hF, 7'd10},                          // R3 zero count runs once
    {4'h0, 7'd11}, {4'h1, 7'd12}, {4'h2, 7'd11},           // R7 not taken, taken
    {4'hF, 7'd14}, {4'hF, 7'd15},                          // R8 call from loop
    {4'hF, 7'd20}, {4'hF, 7'd21}, {4'hF, 7'd21}, {4'hF, 7'd22},
    {4'hF, 7'd16}, {4'hF, 7'd15},                          // R8 return restores loop
    {4'hF, 7'd20}, {4'hF, 7'd21}, {4'hF, 7'd21}, {4'hF, 7'd22},
    {4'hF, 7'd16}, {4'hF, 7'd17},
    {4'hF, 7'd18}, {4'hF, 7'd18}, {4'hF, 7'd19},           // R6 jump at loop end suppressed
    {4'hF, 7'd24}                                          // R7 taken jump
  };

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset pc", pc_o, 4);
    chk("R1 reset ovf", ovf_o, 0);
    chk("R1 reset unf", unf_o, 0);
    rst = 1'b0;
    for (int i = 0; i < NROWS; i++) begin
      chk("R2-trace pc", pc_o, VEC[i][6:0]);
      chk("R2 ctrl field", ctrl_o, {4'hA, VEC[i][6:0]});
      cond_i = VEC[i][10:7];
      @(negedge clk);
    end
    // R10: 128 self-calls succeed, the 129th overflows
    for (int k = 2; k <= 129; k++) begin
      chk("R10 self call pc", pc_o, 24);
      chk("R10 ovf low while filling", ovf_o, 0);
      @(negedge clk);
    end
    chk("R10 overflow falls through", pc_o, 25);
    chk("R10 ovf set", ovf_o, 1);
    // R11: 128 returns unwind, the 129th underflows
    for (int k = 1; k <= 129; k++) begin
      chk("R11 return pc", pc_o, 25);
      chk("R11 unf low while unwinding", unf_o, 0);
      @(negedge clk);
    end
    chk("R11 underflow falls through", pc_o, 26);
    chk("R11 unf set", unf_o, 1);
    chk("R10 ovf sticky", ovf_o, 1);
    repeat (2) @(negedge clk);
    chk("R9 halt holds pc", pc_o, 26);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run reset pc", pc_o, 4);
    chk("R1 mid-run reset ovf", ovf_o, 0);
    chk("R1 mid-run reset unf", unf_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 advance after reset", pc_o, 5);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule